// File: doc/BRIEF.md
# Dual-Channel Instruction Break Controller

This block watches the instruction stream that the processor retires and raises a break-exception request when a configured address condition holds. There are two comparison channels, A and B. Each one has a compare address, a per-bit don't-care mask, a mode field and a select bit. The select bit chooses whether the break happens before the watched instruction executes or after it completes. The pipeline is abstracted to one retire event per cycle. Each event carries the address of the instruction that just completed and the address of the instruction that comes next.

Each channel has a sticky match flag that software clears with a strobe. An optional sequential mode arms on a channel-A match and fires only on a later channel-B match. When a break fires, the block registers three things: a one-cycle request, the program counter to be saved, and the branch target. The branch target is either the debug base register or the vector base plus a fixed offset. The block also keeps a copy of the stack-pointer value taken on every exception event.

Top module: `ibrk_unit`

## Requirements
- R1: A channel can hit only when its mode field is 2'b01 (instruction access). Modes 2'b00 (off), 2'b10 (data access) and 2'b11 never hit, and the select bit has no effect in those modes. When the mode is instruction access, the channel hits on a valid retire event exactly when the probed address equals the compare address in every bit whose mask bit is 0. Mask bits set to 1 are don't-care.
- R2: With the select bit at 0 (pre-execution), the probed address is `rt_next_pc`, which is the instruction about to execute. With the select bit at 1 (post-execution), the probed address is `rt_addr`, which is the instruction that just completed. In both cases the reported `brk_spc` is `rt_next_pc`.
- R3: A triggering retire event makes `brk_req` high for exactly the following clock cycle. `brk_spc` and `brk_tgt` are loaded on that same edge and hold their values until the next break.
- R4: When both channels hit in one retire event, one request is produced and both flags are set. For example, post-execution A on address 0x110 and pre-execution B on 0x112 give a single break with `brk_spc` = 0x112.
- R5: With `seq_mode`=1, a channel-A hit raises no request and arms the sequencer. A channel-B hit raises a request only if the sequencer was armed before that event. Every channel-B hit disarms the sequencer. So the sequence A, A, B breaks once, and a following B alone does not break.
- R6: A post-execution hit in the same event as `cexc_pend` (a completed-type exception such as a trap) raises no request, but the channel's flag is still set.
- R7: A post-execution hit in the same event as `rexc_pend` (a re-execution-type exception) raises no request. A pre-execution hit in that event is not affected.
- R8: Flags are sticky. A clear strobe resets a flag in the next cycle, unless that channel hits in the same cycle, in which case the flag stays set.
- R9: `brk_tgt` is `dbg_base` when `dbg_vec_en`=1, and `vec_base` + VEC_OFS (default 0x100) when `dbg_vec_en`=0. The values used are those present at the triggering event.
- R10: `sp_save` takes the value of `sp_in` on every cycle in which `exc_evt` is high or a break triggers, whatever the value of `dbg_vec_en`. At all other times it holds.
- R11: After reset, `brk_req`, both flags, `brk_spc`, `brk_tgt`, `sp_save` and the sequencer state are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_a_mode | input | 2 | Channel A mode (01 = instruction access) |
| ch_a_cmp | input | AW | Channel A compare address |
| ch_a_mask | input | AW | Channel A don't-care mask |
| ch_a_post | input | 1 | Channel A: 1 = break after execution, 0 = before |
| ch_b_mode | input | 2 | Channel B mode |
| ch_b_cmp | input | AW | Channel B compare address |
| ch_b_mask | input | AW | Channel B don't-care mask |
| ch_b_post | input | 1 | Channel B pre/post select |
| seq_mode | input | 1 | A-then-B sequential trigger enable |
| dbg_vec_en | input | 1 | Route breaks to the debug base register |
| dbg_base | input | AW | Debug base register |
| vec_base | input | AW | Vector base register |
| flag_a_clr | input | 1 | Clear strobe for the channel A flag |
| flag_b_clr | input | 1 | Clear strobe for the channel B flag |
| rt_valid | input | 1 | Retire event valid |
| rt_addr | input | AW | Address of the retiring instruction |
| rt_next_pc | input | AW | Address of the next instruction |
| cexc_pend | input | 1 | Completed-type exception in this event |
| rexc_pend | input | 1 | Re-execution-type exception in this event |
| exc_evt | input | 1 | Any other exception event |
| sp_in | input | SPW | Current stack-pointer value |
| brk_req | output | 1 | One-cycle break request |
| brk_spc | output | AW | Saved PC of the last break |
| brk_tgt | output | AW | Branch target of the last break |
| flag_a | output | 1 | Channel A sticky match flag |
| flag_b | output | 1 | Channel B sticky match flag |
| sp_save | output | SPW | Captured stack pointer |

## Verification
Directed patterns separate the two probe points: the same address is presented once as the retiring instruction and once as the next instruction, so a pre/post mix-up shows up. The overlapping A-post / B-pre case separates a merged request from a doubled one. The sequences A-A-B-B and B-before-A show whether arming and disarming happen in the right order. Trap and re-execution events, combined with each select-bit setting, show that suppression acts only on post-execution hits and leaves the flags alone. A long run of random small-valued addresses and masks is compared every cycle against a behavioural model, to catch mask-polarity and mode-decoding errors.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
   typedef enum logic [1:0] {
      CH_OFF  = 2'b00,
      CH_INSN = 2'b01,
      CH_DATA = 2'b10,
      CH_RSVD = 2'b11
   } ch_mode_e;
endpackage

// File: rtl/ibrk_chan.sv
module ibrk_chan
   import ibrk_pkg::*;
#(
   parameter int unsigned AW      = 32,
   parameter bit          MASK_EN = 1'b1
) (
   input  logic [1:0]    mode,
   input  logic [AW-1:0] cmp,
   input  logic [AW-1:0] mask,
   input  logic          post_sel,
   input  logic          rt_valid,
   input  logic [AW-1:0] rt_addr,
   input  logic [AW-1:0] rt_next_pc,
   output logic          hit
);
   logic [AW-1:0] probe;
   logic [AW-1:0] diff;
   ch_mode_e      mode_e;

   assign mode_e = ch_mode_e'(mode);
   // post-execution looks at the completed instruction, pre at the next one
   assign probe  = post_sel ? rt_addr : rt_next_pc;

   generate
      if (MASK_EN) begin : g_masked
         assign diff = (probe ^ cmp) & ~mask;
      end else begin : g_exact
         logic unused_mask;
         assign unused_mask = ^mask;
         assign diff = probe ^ cmp;
      end
   endgenerate

   assign hit = rt_valid && (mode_e == CH_INSN) && (diff == '0);

   // R1: only instruction mode produces hits
   always_comb begin
      a_r1_mode_gate : assert (!(hit && mode_e != CH_INSN));
   end
endmodule

// File: rtl/ibrk_seq.sv
module ibrk_seq #(
   parameter bit SEQ_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seq_mode,
   input  logic hit_a,
   input  logic post_a,
   input  logic hit_b,
   input  logic post_b,
   input  logic cexc,
   input  logic rexc,
   output logic trig
);
   logic seq_on;
   logic armed_q;
   logic blk_a, blk_b, go_a, go_b;

   generate
      if (SEQ_EN) begin : g_seq
         assign seq_on = seq_mode;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          armed_q <= 1'b0;
            else if (!seq_mode)  armed_q <= 1'b0;
            else if (hit_b)      armed_q <= 1'b0;
            else if (hit_a)      armed_q <= 1'b1;
         end
      end else begin : g_noseq
         logic unused_seq;
         assign unused_seq = seq_mode;
         assign seq_on  = 1'b0;
         assign armed_q = 1'b0;
      end
   endgenerate

   // a post-execution break loses to completed or re-execution exceptions
   assign blk_a = post_a && (cexc || rexc);
   assign blk_b = post_b && (cexc || rexc);
   assign go_a  = hit_a && !blk_a && !seq_on;
   assign go_b  = hit_b && !blk_b && (!seq_on || armed_q);
   assign trig  = go_a || go_b;   // simultaneous hits merge into one request

   a_r5_needs_arm : assert property (@(posedge clk) disable iff (!rst_n)
      (seq_on && !armed_q) |-> !trig);
   a_r5_b_disarms : assert property (@(posedge clk) disable iff (!rst_n)
      (seq_on && hit_b) |=> !armed_q);
   a_r6_cexc_blocks_post : assert property (@(posedge clk) disable iff (!rst_n)
      (hit_a && post_a && cexc && !hit_b) |-> !trig);
   a_r7_rexc_blocks_post : assert property (@(posedge clk) disable iff (!rst_n)
      (hit_b && post_b && rexc && !hit_a) |-> !trig);
endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit #(
   parameter int unsigned AW      = 32,
   parameter int unsigned SPW     = 32,
   parameter int unsigned VEC_OFS = 'h100,
   parameter bit          SEQ_EN  = 1'b1,
   parameter bit          MASK_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     ch_a_mode,
   input  logic [AW-1:0]  ch_a_cmp,
   input  logic [AW-1:0]  ch_a_mask,
   input  logic           ch_a_post,
   input  logic [1:0]     ch_b_mode,
   input  logic [AW-1:0]  ch_b_cmp,
   input  logic [AW-1:0]  ch_b_mask,
   input  logic           ch_b_post,
   input  logic           seq_mode,
   input  logic           dbg_vec_en,
   input  logic [AW-1:0]  dbg_base,
   input  logic [AW-1:0]  vec_base,
   input  logic           flag_a_clr,
   input  logic           flag_b_clr,
   input  logic           rt_valid,
   input  logic [AW-1:0]  rt_addr,
   input  logic [AW-1:0]  rt_next_pc,
   input  logic           cexc_pend,
   input  logic           rexc_pend,
   input  logic           exc_evt,
   input  logic [SPW-1:0] sp_in,
   output logic           brk_req,
   output logic [AW-1:0]  brk_spc,
   output logic [AW-1:0]  brk_tgt,
   output logic           flag_a,
   output logic           flag_b,
   output logic [SPW-1:0] sp_save
);
   localparam int unsigned NCH = 2;
   localparam logic [AW-1:0] OFS = AW'(VEC_OFS);

   generate
      if (AW < 4)  begin : g_bad_aw  $error("ibrk_unit: AW below 4"); end
      if (SPW < 1) begin : g_bad_spw $error("ibrk_unit: SPW below 1"); end
   endgenerate

   logic [NCH-1:0]   hit;
   logic [NCH-1:0]   post;
   logic [NCH-1:0]   clr;
   logic [NCH-1:0]   flag_q;
   logic [1:0]       mode   [NCH];
   logic [AW-1:0]    cmp    [NCH];
   logic [AW-1:0]    mask   [NCH];
   logic             trig;

   assign mode[0] = ch_a_mode;  assign mode[1] = ch_b_mode;
   assign cmp[0]  = ch_a_cmp;   assign cmp[1]  = ch_b_cmp;
   assign mask[0] = ch_a_mask;  assign mask[1] = ch_b_mask;
   assign post    = {ch_b_post, ch_a_post};
   assign clr     = {flag_b_clr, flag_a_clr};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ibrk_chan #(.AW(AW), .MASK_EN(MASK_EN)) u_chan (
         .mode       (mode[c]),
         .cmp        (cmp[c]),
         .mask       (mask[c]),
         .post_sel   (post[c]),
         .rt_valid   (rt_valid),
         .rt_addr    (rt_addr),
         .rt_next_pc (rt_next_pc),
         .hit        (hit[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[c] <= 1'b0;
         else        flag_q[c] <= (flag_q[c] & ~clr[c]) | hit[c];
      end
   end

   ibrk_seq #(.SEQ_EN(SEQ_EN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .seq_mode (seq_mode),
      .hit_a    (hit[0]),
      .post_a   (post[0]),
      .hit_b    (hit[1]),
      .post_b   (post[1]),
      .cexc     (cexc_pend),
      .rexc     (rexc_pend),
      .trig     (trig)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_req <= 1'b0;
         brk_spc <= '0;
         brk_tgt <= '0;
         sp_save <= '0;
      end else begin
         brk_req <= trig;
         if (trig) begin
            brk_spc <= rt_next_pc;
            brk_tgt <= dbg_vec_en ? dbg_base : vec_base + OFS;
         end
         if (trig || exc_evt) sp_save <= sp_in;
      end
   end

   assign flag_a = flag_q[0];
   assign flag_b = flag_q[1];

   a_r8_flag_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_a && !flag_a_clr) |=> flag_a);
   a_r8_hit_sets : assert property (@(posedge clk) disable iff (!rst_n)
      hit[1] |=> flag_b);
   a_r4_merge : assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && hit[1] && trig) |=> (brk_req && flag_a && flag_b));
   a_r3_spc : assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (brk_spc == $past(rt_next_pc)));
   a_r3_spc_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !trig |=> $stable(brk_spc));
   a_r9_target : assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (brk_tgt == ($past(dbg_vec_en) ? $past(dbg_base) : $past(vec_base) + OFS)));
   a_r10_sp_capture : assert property (@(posedge clk) disable iff (!rst_n)
      exc_evt |=> (sp_save == $past(sp_in)));
endmodule

// File: tb/ibrk_unit_tb.sv
module ibrk_unit_tb_top;
   localparam int AW = 32;
   localparam int SPW = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic           rst_n;
   logic [1:0]     ch_a_mode, ch_b_mode;
   logic [AW-1:0]  ch_a_cmp, ch_a_mask, ch_b_cmp, ch_b_mask;
   logic           ch_a_post, ch_b_post, seq_mode, dbg_vec_en;
   logic [AW-1:0]  dbg_base, vec_base, rt_addr, rt_next_pc;
   logic           flag_a_clr, flag_b_clr, rt_valid, cexc_pend, rexc_pend, exc_evt;
   logic [SPW-1:0] sp_in;
   logic           brk_req, flag_a, flag_b;
   logic [AW-1:0]  brk_spc, brk_tgt;
   logic [SPW-1:0] sp_save;

   ibrk_unit dut_i (.*);

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // reference model state
   bit        m_armed, m_fa, m_fb, m_req;
   bit [31:0] m_spc, m_tgt, m_sp;

   function automatic bit ref_hit(bit [1:0] md, bit [31:0] c, bit [31:0] mk,
                                  bit pst, bit v, bit [31:0] ra, bit [31:0] np);
      bit [31:0] p;
      if (!v || md != 2'b01) return 1'b0;
      p = pst ? ra : np;
      for (int i = 0; i < 32; i++)
         if (!mk[i] && (p[i] != c[i])) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      rt_valid = 0; cexc_pend = 0; rexc_pend = 0; exc_evt = 0;
      flag_a_clr = 0; flag_b_clr = 0;
   endtask

   // one clock: predict, advance, compare every output
   task automatic tick();
      bit ha, hb, ga, gb, t;
      ha = ref_hit(ch_a_mode, ch_a_cmp, ch_a_mask, ch_a_post, rt_valid, rt_addr, rt_next_pc);
      hb = ref_hit(ch_b_mode, ch_b_cmp, ch_b_mask, ch_b_post, rt_valid, rt_addr, rt_next_pc);
      ga = ha && !(ch_a_post && (cexc_pend || rexc_pend)) && !seq_mode;
      gb = hb && !(ch_b_post && (cexc_pend || rexc_pend)) && (!seq_mode || m_armed);
      t  = ga || gb;
      if (!seq_mode) m_armed = 0;
      else if (hb)   m_armed = 0;
      else if (ha)   m_armed = 1;
      m_req = t;
      if (t) begin
         m_spc = rt_next_pc;
         m_tgt = dbg_vec_en ? dbg_base : vec_base + 32'h100;
      end
      m_fa = (m_fa && !flag_a_clr) || ha;
      m_fb = (m_fb && !flag_b_clr) || hb;
      if (t || exc_evt) m_sp = sp_in;
      @(posedge clk); #2;
      chk(brk_req === m_req, "R3 brk_req", 32'(brk_req), 32'(m_req));
      chk(brk_spc === m_spc, "R2 brk_spc", brk_spc, m_spc);
      chk(brk_tgt === m_tgt, "R9 brk_tgt", brk_tgt, m_tgt);
      chk(flag_a === m_fa, "R8 flag_a", 32'(flag_a), 32'(m_fa));
      chk(flag_b === m_fb, "R8 flag_b", 32'(flag_b), 32'(m_fb));
      chk(sp_save === m_sp, "R10 sp_save", sp_save, m_sp);
      idle_inputs();
   endtask

   task automatic retire(bit [31:0] a, bit [31:0] n);
      rt_valid = 1; rt_addr = a; rt_next_pc = n;
      tick();
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      ch_a_mode = 2'b00; ch_b_mode = 2'b00; ch_a_cmp = 0; ch_b_cmp = 0;
      ch_a_mask = 0; ch_b_mask = 0; ch_a_post = 0; ch_b_post = 0;
      seq_mode = 0; dbg_vec_en = 0; dbg_base = 32'h8000_0000; vec_base = 32'h0000_4000;
      rt_addr = 0; rt_next_pc = 0; sp_in = 32'h1234; idle_inputs();
      repeat (3) @(posedge clk);
      #2;
      // R11: reset state
      chk(brk_req === 0 && flag_a === 0 && flag_b === 0, "R11 reset flags/req",
          {29'd0, brk_req, flag_a, flag_b}, 0);
      chk(brk_spc === 0 && brk_tgt === 0 && sp_save === 0, "R11 reset regs",
          brk_spc | brk_tgt | sp_save, 0);
      @(negedge clk); rst_n = 1;
      m_armed = 0; m_fa = 0; m_fb = 0; m_req = 0; m_spc = 0; m_tgt = 0; m_sp = 0;
      tick();

      // R1: data mode never hits, select bit irrelevant
      ch_a_mode = 2'b10; ch_a_cmp = 32'h200; ch_a_post = 1;
      retire(32'h200, 32'h202);
      chk(brk_req === 0 && flag_a === 0, "R1 data mode no hit", 32'(brk_req), 0);
      ch_a_post = 0; retire(32'h1fe, 32'h200);
      chk(flag_a === 0, "R1 data mode pre no hit", 32'(flag_a), 0);
      // R1: mask don't-care bits
      ch_a_mode = 2'b01; ch_a_mask = 32'h0000_000f;
      retire(32'h100, 32'h20c);
      chk(brk_req === 1 && flag_a === 1, "R1 masked match", 32'(brk_req), 1);
      retire(32'h100, 32'h210);
      chk(brk_req === 0, "R1 unmasked bit differs", 32'(brk_req), 0);
      flag_a_clr = 1; tick();
      chk(flag_a === 0, "R8 clear", 32'(flag_a), 0);

      // R2: pre probes next pc, post probes retiring addr
      ch_a_mask = 0; ch_a_cmp = 32'h300; ch_a_post = 1;
      retire(32'h2fe, 32'h300);
      chk(brk_req === 0, "R2 post ignores next pc", 32'(brk_req), 0);
      retire(32'h300, 32'h302);
      chk(brk_req === 1 && brk_spc === 32'h302, "R2 post spc", brk_spc, 32'h302);
      tick();
      chk(brk_req === 0, "R3 single-cycle pulse", 32'(brk_req), 0);
      chk(brk_spc === 32'h302, "R3 spc holds", brk_spc, 32'h302);

      // R4: merged simultaneous hits
      flag_a_clr = 1; flag_b_clr = 1; tick();
      ch_a_cmp = 32'h110; ch_a_post = 1; ch_b_mode = 2'b01; ch_b_cmp = 32'h112; ch_b_post = 0;
      retire(32'h110, 32'h112);
      chk(brk_req === 1 && flag_a === 1 && flag_b === 1 && brk_spc === 32'h112,
          "R4 merged break", brk_spc, 32'h112);
      tick();
      chk(brk_req === 0, "R4 only one request", 32'(brk_req), 0);

      // R5: sequential A,A,B,B
      flag_a_clr = 1; flag_b_clr = 1; seq_mode = 1; ch_a_post = 0; ch_b_post = 0;
      ch_a_cmp = 32'h400; ch_b_cmp = 32'h500; tick();
      retire(32'h3fe, 32'h500);
      chk(brk_req === 0 && flag_b === 1, "R5 B before A no break", 32'(brk_req), 0);
      retire(32'h3fe, 32'h400);
      chk(brk_req === 0, "R5 A alone no break", 32'(brk_req), 0);
      retire(32'h3fe, 32'h400);
      retire(32'h4fe, 32'h500);
      chk(brk_req === 1 && brk_spc === 32'h500, "R5 A,A,B breaks", 32'(brk_req), 1);
      retire(32'h4fe, 32'h500);
      chk(brk_req === 0, "R5 second B no break", 32'(brk_req), 0);
      seq_mode = 0; ch_b_mode = 2'b00;

      // R6: completed-type exception suppresses post, flag still set
      flag_a_clr = 1; tick();
      ch_a_cmp = 32'h600; ch_a_post = 1;
      rt_valid = 1; rt_addr = 32'h600; rt_next_pc = 32'h602; cexc_pend = 1; tick();
      chk(brk_req === 0 && flag_a === 1, "R6 trap suppresses post", 32'(brk_req), 0);

      // R7: re-execution suppresses post, not pre
      rt_valid = 1; rt_addr = 32'h600; rt_next_pc = 32'h602; rexc_pend = 1; tick();
      chk(brk_req === 0, "R7 rexc suppresses post", 32'(brk_req), 0);
      ch_a_post = 0;
      rt_valid = 1; rt_addr = 32'h5fe; rt_next_pc = 32'h600; rexc_pend = 1; tick();
      chk(brk_req === 1, "R7 pre unaffected", 32'(brk_req), 1);

      // R8: clear and hit in same cycle keeps flag
      rt_valid = 1; rt_addr = 32'h5fe; rt_next_pc = 32'h600; flag_a_clr = 1; tick();
      chk(flag_a === 1, "R8 set wins over clear", 32'(flag_a), 1);

      // R9: target select
      dbg_vec_en = 1; retire(32'h5fe, 32'h600);
      chk(brk_tgt === 32'h8000_0000, "R9 debug base", brk_tgt, 32'h8000_0000);
      dbg_vec_en = 0; retire(32'h5fe, 32'h600);
      chk(brk_tgt === 32'h4100, "R9 vector offset", brk_tgt, 32'h4100);

      // R10: stack pointer capture on exception event
      sp_in = 32'hCAFE; exc_evt = 1; tick();
      chk(sp_save === 32'hCAFE, "R10 capture", sp_save, 32'hCAFE);
      sp_in = 32'hBEEF; tick();
      chk(sp_save === 32'hCAFE, "R10 hold", sp_save, 32'hCAFE);

      // random phase, compared every clock by tick()
      for (int k = 0; k < 3000; k++) begin
         if (k % 50 == 0) begin
            ch_a_mode = 2'($urandom_range(0, 3) == 0 ? 2'b10 : 2'b01);
            ch_b_mode = 2'($urandom_range(0, 3) == 0 ? 2'b00 : 2'b01);
            ch_a_cmp = $urandom_range(0, 15); ch_b_cmp = $urandom_range(0, 15);
            ch_a_mask = $urandom_range(0, 3); ch_b_mask = $urandom_range(0, 3);
            ch_a_post = 1'($urandom); ch_b_post = 1'($urandom);
            seq_mode = 1'($urandom); dbg_vec_en = 1'($urandom);
            dbg_base = $urandom; vec_base = $urandom;
         end
         rt_valid = ($urandom_range(0, 3) != 0);
         rt_addr = $urandom_range(0, 15); rt_next_pc = $urandom_range(0, 15);
         cexc_pend = ($urandom_range(0, 7) == 0); rexc_pend = ($urandom_range(0, 7) == 0);
         exc_evt = ($urandom_range(0, 7) == 0); sp_in = $urandom;
         flag_a_clr = ($urandom_range(0, 3) == 0); flag_b_clr = ($urandom_range(0, 3) == 0);
         tick();
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule